// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block forms the signed product of two two's-complement operands of even width `WIDTH`. It retires two multiplier bits per clock: on every step it looks at three neighbouring bits of the multiplier, with one bit shared between successive looks. From those bits it picks a multiple of the multiplicand (zero, plus or minus once, plus or minus twice) and adds it into a 2·`WIDTH`-bit accumulator. A full product therefore takes `WIDTH/2` steps.

A caller raises `start` for one cycle while the block is idle. The operands are captured on that edge, and `busy` stays high while the steps run. When the last step has been added, `done` pulses for one cycle. The signed result on `product` then stays constant until the next accepted start. The accumulator and the shifted multiplicand are sign-extended to the full product width, so the 2x multiple of the most negative operand cannot wrap.

Top module: `booth_radix4_mul`

## Requirements
- R1: While `rst_n` is low and after it is released, with no start, `busy` and `done` read 0 and `product` reads 0.
- R2: Each step takes the bit triple (upper, middle, lower) of the multiplier. For the first step the lower bit is an implicit 0 below the LSB, and each later triple begins two bits higher. The triple selects the addend as follows: 000 and 111 give 0, 001 and 010 give +x, 011 gives +2x, 100 gives −2x, 101 and 110 give −x. Step k is weighted by 4^k.
- R3: A `start` seen at a rising edge while `busy` is low captures `x_in` and `y_in`, and `busy` is high in the following cycle.
- R4: `done` is high exactly `WIDTH/2` rising edges after the edge that accepted `start`, and it is high for one cycle only.
- R5: When `done` is high, `product` equals the 2·`WIDTH`-bit two's-complement product of the captured operands.
- R6: A `start` raised while `busy` is high has no effect. The running result still uses the operands captured earlier, and no extra `done` follows.
- R7: Operands equal to −2^(`WIDTH`−1), including cases that select ±2x, give the exact signed product within 2·`WIDTH` bits.
- R8: While the block is idle and `start` is low, `product` keeps its value.
- R9: `busy` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiplication; accepted only when idle |
| x_in | input | WIDTH | Signed multiplicand, captured at accepted start |
| y_in | input | WIDTH | Signed multiplier, captured at accepted start |
| busy | output | 1 | High while recoding steps are in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2*WIDTH | Signed product, held after completion |

## Verification
The in-RTL properties check the handshake on every cycle. They cover the exclusion of `busy` and `done`, the single-cycle `done` pulse, the acceptance of start, the step counter advancing by one per busy cycle, and the holding of `product` while idle. Whether the product value is right depends on the recoding table, the 4^k weighting, the implicit low bit and the guard against overflow of the doubled most negative operand. Only the bench's scenarios can show that. They run chosen multiplier patterns that hit every triple, extreme operands, back-to-back requests and a start injected mid-operation, and compare each result with an independent signed multiply.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Selected multiple for one recoding step: neg applies to one/two.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_digit_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic [2:0]   win,
    output booth_digit_t digit
);

    // R2: triple to signed multiple
    always_comb begin
        digit = '0;
        unique case (win)
            3'b001, 3'b010: digit.one = 1'b1;
            3'b011:         digit.two = 1'b1;
            3'b100: begin
                digit.two = 1'b1;
                digit.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                digit.one = 1'b1;
                digit.neg = 1'b1;
            end
            default:        digit = '0;
        endcase
    end

endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
    import booth_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic [PW-1:0] mcand,
    input  booth_digit_t  digit,
    output logic [PW-1:0] addend,
    output logic          carry_in
);

    logic [PW-1:0] mag;

    always_comb begin
        if (digit.two)
            mag = {mcand[PW-2:0], 1'b0};
        else if (digit.one)
            mag = mcand;
        else
            mag = '0;
        // Negation as inverse plus a carry into the accumulator adder.
        addend   = digit.neg ? ~mag : mag;
        carry_in = digit.neg;
    end

endmodule

// File: rtl/booth_radix4_mul.sv
module booth_radix4_mul
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   x_in,
    input  logic [WIDTH-1:0]   y_in,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW    = 2 * WIDTH;
    localparam int STEPS = WIDTH / 2;
    localparam int CW    = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] step;
        logic [WIDTH:0] ywin;   // multiplier with implicit zero below LSB
        logic [PW-1:0] mcand;   // sign-extended, pre-weighted by 4^step
        logic [PW-1:0] acc;
    } state_t;

    state_t       st_q, st_d;
    booth_digit_t digit;
    logic [PW-1:0] addend;
    logic          carry_in;
    logic [PW-1:0] sum;

    booth_recoder u_recoder (
        .win   (st_q.ywin[2:0]),
        .digit (digit)
    );

    booth_ppgen #(.PW(PW)) u_ppgen (
        .mcand    (st_q.mcand),
        .digit    (digit),
        .addend   (addend),
        .carry_in (carry_in)
    );

    assign sum = st_q.acc + addend + PW'(carry_in);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.step  = '0;
                st_d.ywin  = {y_in, 1'b0};
                st_d.mcand = {{WIDTH{x_in[WIDTH-1]}}, x_in};
                st_d.acc   = '0;
            end
        end else begin
            st_d.acc   = sum;
            st_d.mcand = {st_q.mcand[PW-3:0], 2'b00};
            st_d.ywin  = {{2{st_q.ywin[WIDTH]}}, st_q.ywin[WIDTH:2]};
            st_d.step  = st_q.step + 1'b1;
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign product = st_q.acc;

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.step != LAST_STEP) |=> (busy && st_q.step == $past(st_q.step) + 1'b1));

    // R6
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && st_q.step != LAST_STEP) |=> (busy && st_q.step != '0));

    // R8
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

// File: tb/booth_radix4_mul_test.sv
module booth_radix4_mul_test;

    localparam int  W      = 8;
    localparam int  STEPS  = W / 2;
    localparam time PERIOD = 10;

    typedef struct {
        string          tag;
        logic [2*W-1:0] val;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic [W-1:0]   x;
    logic [W-1:0]   y;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int    n_chk = 0;
    int    n_bad = 0;
    item_t exp_q[$];

    booth_radix4_mul #(.WIDTH(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .x_in    (x),
        .y_in    (y),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
        logic signed [2*W-1:0] sa, sb, p;
        sa = $signed({{W{a[W-1]}}, a});
        sb = $signed({{W{b[W-1]}}, b});
        p  = sa * sb;
        return p;
    endfunction

    // Monitor: compare each completion against the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected done", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.tag, 64'(product), 64'(it.val));
            end
        end
    end

    // Driver: issues one request, checks handshake timing.
    task automatic run_op(string tag, logic [W-1:0] a, logic [W-1:0] b, bit inject);
        int cnt;
        item_t it;
        while (busy) @(negedge clk);
        x = a;
        y = b;
        start = 1'b1;
        it.tag = tag;
        it.val = ref_mul(a, b);
        exp_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        check("R3 busy after start", 64'(busy), 64'd1);
        cnt = 1;
        while (!done && cnt < 100) begin
            if (busy && done) check("R9 busy with done", 64'd1, 64'd0);
            if (inject && cnt == 2) begin
                start = 1'b1;
                x = ~a;
                y = b + 8'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check("R4 latency", 64'(cnt), 64'(STEPS + 1));
        check("R9 busy low at done", 64'(busy), 64'd0);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2*W-1:0] held;
        rst_n = 1'b0;
        start = 1'b0;
        x = '0;
        y = '0;
        repeat (2) @(negedge clk);
        check("R1 busy in reset", 64'(busy), 64'd0);
        check("R1 done in reset", 64'(done), 64'd0);
        check("R1 product in reset", 64'(product), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 busy idle", 64'(busy), 64'd0);
        check("R1 product idle", 64'(product), 64'd0);

        // R2: multiplier patterns reaching every triple
        run_op("R2 y=0",    8'd25,  8'd0,   1'b0);
        run_op("R2 y=1",    8'd25,  8'd1,   1'b0);
        run_op("R2 y=2",    8'd25,  8'd2,   1'b0);
        run_op("R2 y=3",    8'd25,  8'd3,   1'b0);
        run_op("R2 y=-1",   8'd25,  8'hFF,  1'b0);
        run_op("R2 y=-2",   8'd25,  8'hFE,  1'b0);
        run_op("R2 y=0x55", 8'hB3,  8'h55,  1'b0);
        run_op("R2 y=0xAA", 8'hB3,  8'hAA,  1'b0);
        run_op("R2 y=0x6C", 8'd77,  8'h6C,  1'b0);
        run_op("R5 25*-18", 8'd25,  8'hEE,  1'b0);

        // R7: most negative operands
        run_op("R7 min*min", 8'h80, 8'h80, 1'b0);
        run_op("R7 min*max", 8'h80, 8'h7F, 1'b0);
        run_op("R7 max*min", 8'h7F, 8'h80, 1'b0);
        run_op("R7 min*2",   8'h80, 8'h02, 1'b0);
        run_op("R7 min*-2",  8'h80, 8'hFE, 1'b0);

        // R8: result held while idle
        held = ref_mul(8'h80, 8'hFE);
        repeat (4) @(negedge clk);
        check("R8 product held", 64'(product), 64'(held));

        // R6: start during busy is ignored
        run_op("R6 inject", 8'd99, 8'hC5, 1'b1);
        repeat (STEPS + 3) @(negedge clk);
        check("R6 still idle", 64'(busy), 64'd0);
        check("R6 queue drained", 64'(exp_q.size()), 64'd0);
        check("R8 held after ignored start", 64'(product), 64'(ref_mul(8'd99, 8'hC5)));

        // R5: random operands, back to back
        for (int i = 0; i < 150; i++) begin
            run_op("R5 random", W'($urandom), W'($urandom), 1'b0);
        end

        repeat (4) @(negedge clk);
        check("R5 scoreboard empty", 64'(exp_q.size()), 64'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule